// File: doc/BRIEF.md
# Debug Event Halt Controller

This block sits beside a small processor core and decides, each cycle, what the core does when a debug event arrives. Six single-cycle event pulses come in: breakpoint match, watchpoint match, vector catch, performance counter overflow, the external debug request pin, and a halt request from the attached debugger. Depending on a two-bit control register, a qualifying event either freezes the core or raises a debug monitor exception request for a software handler. Freezing means the core clock enable drops, instruction issue stalls and interrupts are masked.

Every accepted event leaves a sticky bit in a cause status register. Software or the debugger reads that register to learn why the core stopped or trapped, and clears bits by writing ones. A restart input leaves the frozen state. Whether the monitor exception path exists at all is fixed at build time by a parameter. The debugger's own halt request halts the core whatever the control register holds.

Register writes arrive on a simple write strobe with a one-bit select. Select 0 writes the control register: bit 0 enables halting and bit 1 enables monitor mode. Select 1 is a write-one-to-clear access to the cause status register.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: The cause status bit positions are fixed: bit 0 breakpoint, bit 1 watchpoint, bit 2 vector catch, bit 3 counter overflow, bit 4 external debug request, bit 5 debugger halt request.
- R2: With the halting-enable bit (control bit 0) set, any event pulse makes `halted_o` high from the next cycle.
- R3: While `halted_o` is high, `core_clk_en_o` is low and `issue_stall_o` and `irq_mask_o` are high. While running, all three have the opposite values.
- R4: Status bits are sticky and accumulate. A write with select 1 clears each bit whose data bit is 1. An event that sets a bit in the same cycle as a clear of that bit wins.
- R5: With monitor support built in, control bit 1 set, control bit 0 clear and the core running, an event other than the debugger halt request raises `mon_req_o` from the next cycle and records its cause. The request holds until `mon_ack_i`. Events arriving while the request is pending only set status bits.
- R6: With monitor support left out, `mon_req_o` never rises and control bit 1 has no effect: with bit 0 clear, events other than the debugger halt request set no status bit.
- R7: With both control bits clear, events other than the debugger halt request are ignored and set no status bit.
- R8: The debugger halt request always halts the core from the next cycle and sets status bit 5, for any control setting.
- R9: `restart_i` while halted makes `halted_o` low from the next cycle. A halting event in that same cycle keeps the core halted. Without a restart the core stays halted.
- R10: With both control bits set, halting takes precedence and no monitor request is raised.
- R11: After reset the core runs, no request is pending, status is zero and both control bits are zero. A control write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bkpt_hit_i | input | 1 | Breakpoint match pulse |
| watch_hit_i | input | 1 | Watchpoint match pulse |
| vcatch_hit_i | input | 1 | Vector catch pulse |
| pmu_ovf_i | input | 1 | Performance counter overflow pulse |
| ext_dbgreq_i | input | 1 | External debug request pin |
| host_halt_i | input | 1 | Halt request from the debugger |
| restart_i | input | 1 | Restart request |
| mon_ack_i | input | 1 | Monitor exception acknowledge |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 1 | 0 selects control, 1 selects status clear |
| reg_wr_data_i | input | 6 | Write data |
| halted_o | output | 1 | Core is in the halted debug state |
| core_clk_en_o | output | 1 | Core clock enable |
| issue_stall_o | output | 1 | Instruction issue stall |
| irq_mask_o | output | 1 | Interrupt servicing mask |
| mon_req_o | output | 1 | Debug monitor exception request |
| cause_status_o | output | 6 | Sticky cause status register |

## Verification
A wrong halted state shows on the next clock edge as a disagreement on all four run-control outputs together. The reference model compares them every cycle, so such an error is caught within one cycle of the edge that caused it. A wrong monitor-pending bit shows as a request that appears, lingers past an acknowledge or never rises. A wrong control register shows only when the next event arrives. The bench therefore follows every control write with events of each kind, and runs a second instance built without monitor support side by side on the same stimulus.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int NUM_CAUSE = 6;
  localparam int REG_W     = NUM_CAUSE;

  // status bit positions, visible to software
  localparam int C_BKPT   = 0;
  localparam int C_WATCH  = 1;
  localparam int C_VCATCH = 2;
  localparam int C_PMUOVF = 3;
  localparam int C_EXTREQ = 4;
  localparam int C_HOST   = 5;

  // control register fields
  localparam int CTL_W       = 2;
  localparam int CTL_HALT_EN = 0;
  localparam int CTL_MON_EN  = 1;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef struct packed {
    logic mon_en;
    logic halt_en;
  } dbg_ctrl_t;
endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_halt_pkg::*;
#(
  parameter bit MON_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTL_W-1:0] wr_data,
  output dbg_ctrl_t        ctrl
);
  dbg_ctrl_t ctrl_q, ctrl_d;
  logic      ctrl_we;

  assign ctrl_we = wr_en && (wr_sel == SEL_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.halt_en = wr_data[CTL_HALT_EN];
      ctrl_d.mon_en  = wr_data[CTL_MON_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // monitor selection is masked off entirely when the path is not built
  always_comb begin
    ctrl.halt_en = ctrl_q.halt_en;
    ctrl.mon_en  = MON_SUPPORT && ctrl_q.mon_en;
  end
endmodule

// File: rtl/dbg_cause_status.sv
module dbg_cause_status
  import dbg_halt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] cause_set,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NUM_CAUSE-1:0] status
);
  logic [NUM_CAUSE-1:0] st_q, st_d;
  logic                 clr_we;

  assign clr_we = wr_en && (wr_sel == SEL_STAT);

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
    // a new event beats a simultaneous clear
    always_comb begin
      st_d[i] = st_q[i];
      if (clr_we && wr_data[i]) st_d[i] = 1'b0;
      if (cause_set[i])         st_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_halt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dbg_ctrl_t            ctrl,
  input  logic [NUM_CAUSE-1:0] evt,
  input  logic                 restart,
  input  logic                 mon_ack,
  output logic                 halted,
  output logic                 mon_pend,
  output logic [NUM_CAUSE-1:0] cause_set
);
  localparam int N_QUAL = NUM_CAUSE - 1;

  logic [N_QUAL-1:0] qual_evt;
  logic              any_qual, host_req;
  logic              stay_halted, halt_trig, mon_trig, accept;
  logic              halted_q, halted_d;
  logic              pend_q, pend_d;

  assign qual_evt = evt[N_QUAL-1:0];
  assign host_req = evt[C_HOST];
  assign any_qual = |qual_evt;

  always_comb begin
    stay_halted = halted_q && !restart;
    halt_trig   = host_req || (ctrl.halt_en && any_qual);
    mon_trig    = ctrl.mon_en && !ctrl.halt_en && !host_req
                  && !stay_halted && any_qual;
    accept      = ctrl.halt_en || ctrl.mon_en;

    halted_d = stay_halted || halt_trig;

    if (pend_q) pend_d = !mon_ack;
    else        pend_d = mon_trig;

    cause_set         = '0;
    cause_set[C_HOST] = host_req;
    if (accept) cause_set[N_QUAL-1:0] = qual_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      halted_q <= halted_d;
      pend_q   <= pend_d;
    end
  end

  assign halted   = halted_q;
  assign mon_pend = pend_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter bit MON_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkpt_hit_i,
  input  logic             watch_hit_i,
  input  logic             vcatch_hit_i,
  input  logic             pmu_ovf_i,
  input  logic             ext_dbgreq_i,
  input  logic             host_halt_i,
  input  logic             restart_i,
  input  logic             mon_ack_i,
  input  logic             reg_wr_en_i,
  input  logic             reg_wr_sel_i,
  input  logic [REG_W-1:0] reg_wr_data_i,
  output logic             halted_o,
  output logic             core_clk_en_o,
  output logic             issue_stall_o,
  output logic             irq_mask_o,
  output logic             mon_req_o,
  output logic [REG_W-1:0] cause_status_o
);
  logic                 rst_s1_q, rst_sync_n;
  dbg_ctrl_t            ctrl;
  logic [NUM_CAUSE-1:0] evt_vec, cause_set;
  logic                 halted;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  always_comb begin
    evt_vec           = '0;
    evt_vec[C_BKPT]   = bkpt_hit_i;
    evt_vec[C_WATCH]  = watch_hit_i;
    evt_vec[C_VCATCH] = vcatch_hit_i;
    evt_vec[C_PMUOVF] = pmu_ovf_i;
    evt_vec[C_EXTREQ] = ext_dbgreq_i;
    evt_vec[C_HOST]   = host_halt_i;
  end

  dbg_ctrl_regs #(.MON_SUPPORT(MON_SUPPORT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en_i),
    .wr_sel  (reg_wr_sel_i),
    .wr_data (reg_wr_data_i[CTL_W-1:0]),
    .ctrl    (ctrl)
  );

  dbg_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl      (ctrl),
    .evt       (evt_vec),
    .restart   (restart_i),
    .mon_ack   (mon_ack_i),
    .halted    (halted),
    .mon_pend  (mon_req_o),
    .cause_set (cause_set)
  );

  dbg_cause_status u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cause_set (cause_set),
    .wr_en     (reg_wr_en_i),
    .wr_sel    (reg_wr_sel_i),
    .wr_data   (reg_wr_data_i),
    .status    (cause_status_o)
  );

  assign halted_o      = halted;
  assign core_clk_en_o = !halted;
  assign issue_stall_o = halted;
  assign irq_mask_o    = halted;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
  import dbg_halt_pkg::*;
#(
  parameter bit MON_SUPPORT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bkpt_hit_i,
  input logic             watch_hit_i,
  input logic             vcatch_hit_i,
  input logic             pmu_ovf_i,
  input logic             ext_dbgreq_i,
  input logic             host_halt_i,
  input logic             restart_i,
  input logic             mon_ack_i,
  input logic             reg_wr_en_i,
  input logic             reg_wr_sel_i,
  input logic [REG_W-1:0] reg_wr_data_i,
  input logic             halted_o,
  input logic             core_clk_en_o,
  input logic             issue_stall_o,
  input logic             irq_mask_o,
  input logic             mon_req_o,
  input logic [REG_W-1:0] cause_status_o
);
  logic any_evt;
  assign any_evt = bkpt_hit_i || watch_hit_i || vcatch_hit_i || pmu_ovf_i
                   || ext_dbgreq_i || host_halt_i;

  assert_host_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_halt_i |=> (halted_o && cause_status_o[C_HOST]));

  assert_frozen_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!core_clk_en_o && issue_stall_o && irq_mask_o));

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !restart_i) |=> halted_o);

  assert_restart_leaves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && restart_i && !any_evt) |=> !halted_o);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_req_o && !mon_ack_i) |=> mon_req_o);

  assert_req_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_req_o && mon_ack_i) |=> !mon_req_o);

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_sticky
    assert_bit_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_status_o[i] && !(reg_wr_en_i && reg_wr_sel_i && reg_wr_data_i[i]))
        |=> cause_status_o[i]);
  end

  if (!MON_SUPPORT) begin : g_nomon
    assert_no_monitor_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_req_o);
  end
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.MON_SUPPORT(MON_SUPPORT)) chk_i (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .bkpt_hit_i     (bkpt_hit_i),
  .watch_hit_i    (watch_hit_i),
  .vcatch_hit_i   (vcatch_hit_i),
  .pmu_ovf_i      (pmu_ovf_i),
  .ext_dbgreq_i   (ext_dbgreq_i),
  .host_halt_i    (host_halt_i),
  .restart_i      (restart_i),
  .mon_ack_i      (mon_ack_i),
  .reg_wr_en_i    (reg_wr_en_i),
  .reg_wr_sel_i   (reg_wr_sel_i),
  .reg_wr_data_i  (reg_wr_data_i),
  .halted_o       (halted_o),
  .core_clk_en_o  (core_clk_en_o),
  .issue_stall_o  (issue_stall_o),
  .irq_mask_o     (irq_mask_o),
  .mon_req_o      (mon_req_o),
  .cause_status_o (cause_status_o)
);

// File: tb/dbg_halt_ctrl_tb_top.sv
module dbg_halt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev = '0;      // bit order as in R1
  logic       rs = 1'b0, ak = 1'b0, we = 1'b0, sel = 1'b0;
  logic [5:0] wd = '0;

  logic       h0, ce0, st0, im0, mr0;
  logic [5:0] cs0;
  logic       h1, ce1, st1, im1, mr1;
  logic [5:0] cs1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctrl #(.MON_SUPPORT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bkpt_hit_i(ev[0]), .watch_hit_i(ev[1]), .vcatch_hit_i(ev[2]),
    .pmu_ovf_i(ev[3]), .ext_dbgreq_i(ev[4]), .host_halt_i(ev[5]),
    .restart_i(rs), .mon_ack_i(ak),
    .reg_wr_en_i(we), .reg_wr_sel_i(sel), .reg_wr_data_i(wd),
    .halted_o(h0), .core_clk_en_o(ce0), .issue_stall_o(st0),
    .irq_mask_o(im0), .mon_req_o(mr0), .cause_status_o(cs0)
  );

  dbg_halt_ctrl #(.MON_SUPPORT(1'b0)) dut_nomon_i (
    .clk(clk), .rst_n(rst_n),
    .bkpt_hit_i(ev[0]), .watch_hit_i(ev[1]), .vcatch_hit_i(ev[2]),
    .pmu_ovf_i(ev[3]), .ext_dbgreq_i(ev[4]), .host_halt_i(ev[5]),
    .restart_i(rs), .mon_ack_i(ak),
    .reg_wr_en_i(we), .reg_wr_sel_i(sel), .reg_wr_data_i(wd),
    .halted_o(h1), .core_clk_en_o(ce1), .issue_stall_o(st1),
    .irq_mask_o(im1), .mon_req_o(mr1), .cause_status_o(cs1)
  );

  // behavioural reference state
  typedef struct {
    bit       halted;
    bit       req;
    bit [5:0] stat;
    bit       hen;
    bit       men;
  } ref_t;

  ref_t m0, m1;

  function automatic ref_t ref_step(ref_t c, bit sup, bit [5:0] e, bit rst_req,
                                    bit ack, bit wen, bit wsel, bit [5:0] d);
    ref_t n = c;
    bit monitor_on = sup && c.men;
    bit other = (e[4:0] != 0);
    bit still = c.halted && !rst_req;
    n.halted = still || e[5] || (c.hen && other);          // R2 R8 R9
    if (c.req) n.req = !ack;                                 // R5
    else n.req = monitor_on && !c.hen && !e[5] && !still && other;
    for (int i = 0; i < 6; i++) begin                        // R4
      if (wen && wsel && d[i]) n.stat[i] = 1'b0;
    end
    for (int i = 0; i < 5; i++) begin                        // R7 R6
      if (e[i] && (c.hen || monitor_on)) n.stat[i] = 1'b1;
    end
    if (e[5]) n.stat[5] = 1'b1;
    if (wen && !wsel) begin                                  // R11
      n.hen = d[0];
      n.men = d[1];
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0 <= '{default: 0};
      m1 <= '{default: 0};
    end else begin
      m0 <= ref_step(m0, 1'b1, ev, rs, ak, we, sel, wd);
      m1 <= ref_step(m1, 1'b0, ev, rs, ak, we, sel, wd);
    end
  end

  task automatic chk1(string tag, string what, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b",
               tag, what, cycles, act, exp_v);
    end
  endtask

  task automatic chk6(string tag, string what, logic [5:0] act, logic [5:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b",
               tag, what, cycles, act, exp_v);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    chk1("R2", "halted", h0, m0.halted);
    chk1("R3", "clk_en", ce0, !m0.halted);
    chk1("R3", "stall", st0, m0.halted);
    chk1("R3", "irq_mask", im0, m0.halted);
    chk1("R5", "mon_req", mr0, m0.req);
    chk6("R4", "status", cs0, m0.stat);
    chk1("R6", "nomon halted", h1, m1.halted);
    chk1("R6", "nomon clk_en", ce1, !m1.halted);
    chk1("R6", "nomon mon_req", mr1, m1.req);
    chk6("R6", "nomon status", cs1, m1.stat);
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
      summary();
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drv(bit [5:0] e, bit r = 0, bit a = 0,
                     bit w = 0, bit s = 0, bit [5:0] d = 0);
    @(negedge clk);
    #1;
    ev = e; rs = r; ak = a; we = w; sel = s; wd = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(6'b0);
  endtask

  task automatic wr_ctrl(bit [1:0] v);
    drv(6'b0, 0, 0, 1, 0, {4'b0, v});
  endtask

  task automatic wr_clear(bit [5:0] v);
    drv(6'b0, 0, 0, 1, 1, v);
  endtask

  initial begin
    // R11: reset state compared while held and after release
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    chk6("R11", "status after reset", cs0, 6'b0);
    chk1("R11", "running after reset", h0, 1'b0);

    // R7: nothing enabled, ordinary events leave no trace
    for (int i = 0; i < 5; i++) drv(6'b1 << i);
    idle(2);
    chk6("R7", "ignored events", cs0, 6'b0);

    // R8: debugger halt request halts with everything disabled
    drv(6'b100000); idle(2);
    chk1("R8", "host halt", h0, 1'b1);
    chk6("R8", "host bit", cs0, 6'b100000);
    // R9: stays halted, then restart
    idle(3);
    drv(6'b0, 1); idle(2);
    chk1("R9", "restart", h0, 1'b0);
    wr_clear(6'b100000); idle(1);

    // R11 R2 R1: enable halting, breakpoint halts and sets bit 0
    wr_ctrl(2'b01);
    drv(6'b000001); idle(2);
    chk1("R2", "bkpt halt", h0, 1'b1);
    chk6("R1", "bkpt bit", cs0, 6'b000001);
    // R9: restart together with a watchpoint stays halted
    drv(6'b000010, 1); idle(2);
    chk1("R9", "restart plus event", h0, 1'b1);
    chk6("R4", "accumulate", cs0, 6'b000011);
    drv(6'b0, 1); idle(1);
    // each cause halts in turn
    for (int i = 2; i < 5; i++) begin
      drv(6'b1 << i); idle(1);
      drv(6'b0, 1); idle(1);
    end
    chk6("R1", "all ordinary causes", cs0, 6'b011111);
    // R4: partial clear, then clear with a simultaneous set
    wr_clear(6'b000101); idle(1);
    chk6("R4", "partial clear", cs0, 6'b011010);
    drv(6'b001000, 0, 0, 1, 1, 6'b001000); idle(1);
    chk6("R4", "set beats clear", cs0, 6'b011010);
    drv(6'b0, 1); wr_clear(6'b111111); idle(1);

    // R10: both enabled, halting wins
    wr_ctrl(2'b11);
    drv(6'b000100); idle(2);
    chk1("R10", "halt wins", h0, 1'b1);
    chk1("R10", "no request", mr0, 1'b0);
    drv(6'b0, 1); wr_clear(6'b111111); idle(1);

    // R5 R6: monitor only
    wr_ctrl(2'b10);
    drv(6'b001000); idle(2);
    chk1("R5", "monitor request", mr0, 1'b1);
    chk1("R5", "not halted", h0, 1'b0);
    chk1("R6", "nomon no request", mr1, 1'b0);
    chk6("R6", "nomon no status", cs1, 6'b0);
    drv(6'b010000); idle(3);
    chk1("R5", "held", mr0, 1'b1);
    chk6("R5", "status only", cs0, 6'b011000);
    drv(6'b0, 0, 1); idle(2);
    chk1("R5", "acked", mr0, 1'b0);
    // ack together with an event: no new request
    drv(6'b000010); drv(6'b000001, 0, 1); idle(2);
    chk1("R5", "ack with event", mr0, 1'b0);
    // host halt under monitor config, then event while halted
    drv(6'b100000); drv(6'b000001); idle(2);
    chk1("R8", "host halt in monitor", h0, 1'b1);
    chk1("R5", "no request while halted", mr0, 1'b0);
    drv(6'b0, 1); idle(2);
    wr_ctrl(2'b00); wr_clear(6'b111111); idle(1);
    drv(6'b010000); idle(2);
    chk6("R7", "disabled again", cs0, 6'b0);

    idle(4);
    summary();
  end
endmodule